// File: doc/BRIEF.md
# Buck PWM conduction-mode controller

This block sequences the two gate enables of a synchronous buck power stage. A fixed-rate cycle-start pulse opens each switching period. The comparator bit from the external PWM ramp sets how long the high side conducts. A zero-crossing comparator bit reports when inductor current has reached zero. The block adds a dead gap of a few clock cycles at every handover between the two switches. It caps the on-time to limit duty cycle, and it refuses to begin a new pulse until a minimum off time has passed.

A static mode input picks one of two behaviours. In forced continuous mode the low side conducts for the whole off-time and every period switches. In automatic mode a zero crossing cuts the low side off. With both switches idle, a period whose comparator bit is low at cycle start is skipped, so light loads switch less often. The `ccm_o` status bit reports continuous conduction. While the soft-start ramp is still below the sensed output (pre-bias start), the low side is held off. A global enable forces both switches off in the same cycle.

Top module: `buck_gate_seq`

## Requirements
- R1: While rst_ni is low, hs_en_o and ls_en_o are 0, and ccm_o is 0 when auto_mode_i is 1.
- R2: A start is accepted when cyc_start_i and pwm_cmp_i are both 1, both switches are idle or the low side is on, and the minimum off time has elapsed. After DEAD_CYC cycles with both enables low, hs_en_o stays 1 while pwm_cmp_i is 1. Then, after DEAD_CYC more low cycles, ls_en_o stays 1 until the next accepted start.
- R3: hs_en_o and ls_en_o are never 1 together, and every handover between them includes at least one cycle (DEAD_CYC cycles in normal sequencing) with both low.
- R4: hs_en_o is never 1 for more than MAX_ON_CYC consecutive cycles, even when pwm_cmp_i stays 1.
- R5: Once hs_en_o falls, it stays 0 for at least MIN_OFF_CYC + DEAD_CYC cycles unless en_i drops in between. A start that arrives earlier is dropped.
- R6: With auto_mode_i = 1, zc_i = 1 while ls_en_o is 1 turns ls_en_o off from the next cycle. It stays off until the next accepted start.
- R7: A cycle start with pwm_cmp_i = 0 produces no switching. From the idle state both enables stay 0.
- R8: In automatic mode, ccm_o (1 = continuous, 0 = discontinuous) rises at the second consecutive accepted start that finds the low side still conducting.
- R9: In automatic mode, a zero-crossing event (zc_i = 1 while the low side conducts) drives ccm_o to 0 on the next cycle and restarts the count. It takes priority over a start in the same cycle, and that start still proceeds.
- R10: With auto_mode_i = 0, ccm_o is 1 and zc_i has no effect on ls_en_o.
- R11: While prebias_i is 1, ls_en_o is 0 in the same cycle. After prebias_i falls, the low side returns only through the handover that follows the next pulse.
- R12: en_i = 0 forces hs_en_o and ls_en_o to 0 in the same cycle. It returns the block to idle and clears the conduction-mode count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable; 0 forces both switches off |
| auto_mode_i | input | 1 | 1 = automatic CCM/DCM, 0 = forced continuous |
| cyc_start_i | input | 1 | One-cycle pulse opening each switching period |
| pwm_cmp_i | input | 1 | Ramp comparator; 1 requests high-side conduction |
| zc_i | input | 1 | Inductor current zero-crossing comparator |
| prebias_i | input | 1 | 1 while the soft-start ramp is below the feedback level |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| ccm_o | output | 1 | 1 = continuous conduction, 0 = discontinuous |

## Verification
The two events that can land in the same cycle are a zero crossing and the next period's start, both seen while the low side conducts. The bench first builds continuous conduction with clean periods. It then raises zc_i on the exact cycle of a cycle-start pulse. The result is judged on two counts: ccm_o must fall on the next cycle, and the high side must still rise after the dead gap, so the start is not lost. Random runs with frequent zero crossings and irregular start spacing make the same collision happen again, and a bench reference model checks every cycle.

// File: rtl/buck_gate_pkg.sv
`timescale 1ns/1ps
package buck_gate_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEAD_H,
    PH_HIGH,
    PH_DEAD_L,
    PH_LOW
  } phase_e;
endpackage

// File: rtl/buck_phase_fsm.sv
`timescale 1ns/1ps
module buck_phase_fsm
  import buck_gate_pkg::*;
#(
  parameter int DEAD_CYC    = 2,
  parameter int MAX_ON_CYC  = 152,
  parameter int MIN_OFF_CYC = 24
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   auto_mode_i,
  input  logic   cyc_start_i,
  input  logic   pwm_cmp_i,
  input  logic   zc_i,
  input  logic   prebias_i,
  output phase_e phase_o,
  output logic   start_ls_o,
  output logic   zc_evt_o
);
  localparam int CNT_MAX = (MAX_ON_CYC > DEAD_CYC) ? MAX_ON_CYC : DEAD_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int OW = $clog2(MIN_OFF_CYC + 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] ON_LAST   = CW'(MAX_ON_CYC - 1);
  localparam logic [OW-1:0] OFF_SAT   = OW'(MIN_OFF_CYC);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] off_q, off_d;
  logic          start_ok, zc_evt;

  // start only from a settled phase and after the off window
  assign start_ok = cyc_start_i & pwm_cmp_i & (off_q >= OFF_SAT) &
                    ((ph_q == PH_IDLE) | (ph_q == PH_LOW));
  assign zc_evt   = auto_mode_i & zc_i & (ph_q == PH_LOW);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_HIGH)       off_d = '0;
    else if (off_q != OFF_SAT) off_d = off_q + OW'(1);
    else                       off_d = off_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_ok) begin ph_d = PH_DEAD_H; cnt_d = '0; end
      end
      PH_DEAD_H: begin
        if (cnt_q == DEAD_LAST) begin ph_d = PH_HIGH; cnt_d = '0; end
        else cnt_d = cnt_q + CW'(1);
      end
      PH_HIGH: begin
        if (!pwm_cmp_i || cnt_q == ON_LAST) begin ph_d = PH_DEAD_L; cnt_d = '0; end
        else cnt_d = cnt_q + CW'(1);
      end
      PH_DEAD_L: begin
        if (cnt_q == DEAD_LAST) begin
          ph_d  = prebias_i ? PH_IDLE : PH_LOW;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      PH_LOW: begin
        if (start_ok) begin ph_d = PH_DEAD_H; cnt_d = '0; end
        else if (zc_evt || prebias_i) ph_d = PH_IDLE;
      end
      default: begin ph_d = PH_IDLE; cnt_d = '0; end
    endcase
    if (!en_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
      off_d = OFF_SAT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      off_q <= OFF_SAT;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign phase_o    = ph_q;
  assign start_ls_o = en_i & start_ok & (ph_q == PH_LOW);
  assign zc_evt_o   = en_i & zc_evt;
endmodule

// File: rtl/buck_cond_track.sv
`timescale 1ns/1ps
module buck_cond_track #(
  parameter int CCM_RUNS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic auto_mode_i,
  input  logic start_ls_i,
  input  logic zc_evt_i,
  output logic ccm_o
);
  localparam int RW = $clog2(CCM_RUNS + 1);
  localparam logic [RW-1:0] RUNS_V = RW'(CCM_RUNS);

  logic [RW-1:0] run_q;
  logic          ccm_q;

  // zero crossing beats a coincident start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      ccm_q <= 1'b0;
    end else if (!en_i || !auto_mode_i || zc_evt_i) begin
      run_q <= '0;
      ccm_q <= 1'b0;
    end else if (start_ls_i) begin
      if (run_q != RUNS_V) run_q <= run_q + RW'(1);
      if (run_q >= RUNS_V - RW'(1)) ccm_q <= 1'b1;
    end
  end

  assign ccm_o = ~auto_mode_i | ccm_q;
endmodule

// File: rtl/buck_gate_seq.sv
`timescale 1ns/1ps
module buck_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int DEAD_CYC    = 2,
  parameter int MAX_ON_CYC  = 152,
  parameter int MIN_OFF_CYC = 24,
  parameter int CCM_RUNS    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic auto_mode_i,
  input  logic cyc_start_i,
  input  logic pwm_cmp_i,
  input  logic zc_i,
  input  logic prebias_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic ccm_o
);
  phase_e phase;
  logic   start_ls, zc_evt;

  buck_phase_fsm #(
    .DEAD_CYC   (DEAD_CYC),
    .MAX_ON_CYC (MAX_ON_CYC),
    .MIN_OFF_CYC(MIN_OFF_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .auto_mode_i(auto_mode_i),
    .cyc_start_i(cyc_start_i),
    .pwm_cmp_i  (pwm_cmp_i),
    .zc_i       (zc_i),
    .prebias_i  (prebias_i),
    .phase_o    (phase),
    .start_ls_o (start_ls),
    .zc_evt_o   (zc_evt)
  );

  buck_cond_track #(
    .CCM_RUNS(CCM_RUNS)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .auto_mode_i(auto_mode_i),
    .start_ls_i (start_ls),
    .zc_evt_i   (zc_evt),
    .ccm_o      (ccm_o)
  );

  // enable and pre-bias gate the registered phase without a clock of delay
  assign hs_en_o = en_i & (phase == PH_HIGH);
  assign ls_en_o = en_i & ~prebias_i & (phase == PH_LOW);
endmodule

// File: rtl/buck_gate_seq_chk.sv
`timescale 1ns/1ps
module buck_gate_seq_chk #(
  parameter int DEAD_CYC    = 2,
  parameter int MAX_ON_CYC  = 152,
  parameter int MIN_OFF_CYC = 24
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic auto_mode_i,
  input logic zc_i,
  input logic prebias_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic ccm_o
);
  localparam int HW  = $clog2(MAX_ON_CYC + 2);
  localparam int LIM = MIN_OFF_CYC + DEAD_CYC;
  localparam int LW  = $clog2(LIM + 1);
  localparam logic [HW-1:0] HS_CAP = HW'(MAX_ON_CYC);
  localparam logic [LW-1:0] LO_CAP = LW'(LIM);

  logic [HW-1:0] hs_run;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hs_run <= '0;
    else if (!hs_en_o)                   hs_run <= '0;
    else if (hs_run != HW'(MAX_ON_CYC + 1)) hs_run <= hs_run + HW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             low_run <= LO_CAP;
    else if (!en_i)          low_run <= LO_CAP;
    else if (hs_en_o)        low_run <= '0;
    else if (low_run != LO_CAP) low_run <= low_run + LW'(1);
  end

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));
  p_hs_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_en_o) |=> !ls_en_o);
  p_ls_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_en_o) |=> !hs_en_o);
  p_max_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> (hs_run < HS_CAP));
  p_min_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> (low_run >= LO_CAP));
  p_zc_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && ls_en_o && zc_i) |=> !ls_en_o);
  p_zc_dcm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && ls_en_o && zc_i) |=> !(auto_mode_i && ccm_o));
  p_prebias_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prebias_i |=> !ls_en_o);
  p_disable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hs_en_o && !ls_en_o));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(
  .DEAD_CYC   (DEAD_CYC),
  .MAX_ON_CYC (MAX_ON_CYC),
  .MIN_OFF_CYC(MIN_OFF_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .auto_mode_i(auto_mode_i),
  .zc_i       (zc_i),
  .prebias_i  (prebias_i),
  .hs_en_o    (hs_en_o),
  .ls_en_o    (ls_en_o),
  .ccm_o      (ccm_o)
);

// File: tb/buck_gate_seq_test.sv
`timescale 1ns/1ps
module buck_gate_seq_test;
  localparam int DEAD = 2, MAXON = 152, MINOFF = 24, RUNS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, auto_m = 1'b0, cyc = 1'b0, pwm = 1'b0, zc = 1'b0, pb = 1'b0;
  wire  hs, ls, ccm;
  int   nvec = 0, nfail = 0;
  bit   done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  buck_gate_seq #(
    .DEAD_CYC(DEAD), .MAX_ON_CYC(MAXON), .MIN_OFF_CYC(MINOFF), .CCM_RUNS(RUNS)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .auto_mode_i(auto_m),
    .cyc_start_i(cyc), .pwm_cmp_i(pwm), .zc_i(zc), .prebias_i(pb),
    .hs_en_o(hs), .ls_en_o(ls), .ccm_o(ccm)
  );

  // reference model: 0 idle, 1 dead-before-high, 2 high, 3 dead-before-low, 4 low
  int m_st, m_cnt, m_off, m_n;
  bit m_ccm;
  always @(posedge clk or negedge rst_n) begin : ref_model
    int nst, ncnt;
    bit st_ok, zce;
    if (!rst_n || !en) begin
      m_st = 0; m_cnt = 0; m_off = MINOFF; m_n = 0; m_ccm = 0;
    end else begin
      st_ok = cyc && pwm && (m_off >= MINOFF) && (m_st == 0 || m_st == 4);
      zce   = auto_m && zc && (m_st == 4);
      nst = m_st; ncnt = m_cnt;
      case (m_st)
        0: if (st_ok) begin nst = 1; ncnt = 0; end
        1: if (m_cnt == DEAD - 1) begin nst = 2; ncnt = 0; end else ncnt = m_cnt + 1;
        2: if (!pwm || m_cnt == MAXON - 1) begin nst = 3; ncnt = 0; end else ncnt = m_cnt + 1;
        3: if (m_cnt == DEAD - 1) begin nst = pb ? 0 : 4; ncnt = 0; end else ncnt = m_cnt + 1;
        default: if (st_ok) begin nst = 1; ncnt = 0; end else if (zce || pb) nst = 0;
      endcase
      if (!auto_m || zce) begin m_n = 0; m_ccm = 0; end
      else if (st_ok && m_st == 4) begin
        if (m_n < RUNS) m_n = m_n + 1;
        if (m_n >= RUNS) m_ccm = 1;
      end
      if (m_st == 2) m_off = 0;
      else if (m_off < MINOFF) m_off = m_off + 1;
      m_st = nst; m_cnt = ncnt;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({cur_req, " hs_en_o"}, hs, en && m_st == 2);
    chk({cur_req, " ls_en_o"}, ls, en && !pb && m_st == 4);
    chk({cur_req, " ccm_o"}, ccm, !auto_m || m_ccm);
  endtask

  task automatic idle(int n);
    en = 0; cyc = 0; pwm = 0; zc = 0; pb = 0;
    repeat (n) tick();
    en = 1;
  endtask

  int gap = 182, since = 0, onl = 20;
  task automatic rand_seg(bit am, int zc_pct, int pb_pm, int dis_pm, int n);
    auto_m = am;
    for (int i = 0; i < n; i++) begin
      tick();
      since++;
      if (since >= gap) begin
        cyc = 1; since = 0;
        gap = ($urandom % 4 == 0) ? 10 + int'($urandom % 190) : 182;
        onl = int'($urandom % 200);
      end else cyc = 0;
      pwm = (since < onl);
      zc  = int'($urandom % 100) < zc_pct;
      if (int'($urandom % 1000) < pb_pm) pb = ~pb;
      en  = !(int'($urandom % 1000) < dis_pm);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    en = 1; auto_m = 1;
    cur_req = "R1";
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset hs_en_o", hs, 0);
      chk("R1 reset ls_en_o", ls, 0);
      chk("R1 reset ccm_o", ccm, 0);
    end
    rst_n = 1;

    // R8 entry to CCM, R9 and R6 on a zero crossing
    cur_req = "R8"; auto_m = 1; idle(5);
    for (int k = 0; k < 400; k++) begin
      tick();
      if (k == 150) chk("R8 ccm after one clean start", ccm, 0);
      if (k == 250) chk("R8 ccm after two clean starts", ccm, 1);
      if (k == 262) chk("R9 ccm cleared by crossing", ccm, 0);
      if (k == 262) chk("R6 low side cut by crossing", ls, 0);
      if (k == 290) chk("R6 low side stays off", ls, 0);
      cyc = (k % 100 == 0); pwm = (k % 100) < 20; zc = (k == 260);
    end

    // crossing and cycle start in the same cycle
    cur_req = "R9";
    for (int k = 0; k < 500; k++) begin
      tick();
      if (k == 250) chk("R9 ccm before collision", ccm, 1);
      if (k == 301) chk("R9 ccm after collision", ccm, 0);
      if (k == 303) chk("R9 start kept on collision", hs, 1);
      cyc = (k % 100 == 0); pwm = (k % 100) < 20; zc = (k == 300);
    end

    // R10 forced mode ignores crossings
    cur_req = "R10"; auto_m = 0; idle(5);
    for (int k = 0; k < 300; k++) begin
      tick();
      if (k == 150) chk("R10 ccm in forced mode", ccm, 1);
      if (k == 150) chk("R10 low side ignores zc", ls, 1);
      cyc = (k % 100 == 0); pwm = (k % 100) < 20; zc = 1;
    end

    // R11 pre-bias hold
    cur_req = "R11"; idle(5);
    for (int k = 0; k < 400; k++) begin
      tick();
      if (k == 50 || k == 150) chk("R11 low side held off", ls, 0);
      if (k == 110) chk("R11 high side still pulses", hs, 1);
      if (k == 280) chk("R11 no low side before next pulse", ls, 0);
      if (k == 350) chk("R11 low side after next pulse", ls, 1);
      cyc = (k % 100 == 0); pwm = (k % 100) < 20; zc = 0; pb = (k < 249);
    end

    // R4 on-time cap, R3 dead gap
    cur_req = "R4"; idle(5);
    for (int k = 0; k < 200; k++) begin
      tick();
      if (k == 154) chk("R4 last allowed high cycle", hs, 1);
      if (k == 155) chk("R4 high side capped", hs, 0);
      if (k == 155) chk("R3 dead gap low side", ls, 0);
      if (k == 157) chk("R3 low side after gap", ls, 1);
      if (k == 186) chk("R2 next period switches", hs, 1);
      cyc = (k == 0 || k == 182); pwm = 1;
    end

    // R5 early start dropped
    cur_req = "R5"; idle(5);
    for (int k = 0; k < 100; k++) begin
      tick();
      if (k == 28 || k == 29) chk("R5 early start dropped", hs, 0);
      if (k == 63) chk("R5 later start taken", hs, 1);
      cyc = (k == 0 || k == 25 || k == 60);
      pwm = (k < 5) || (k >= 25 && k < 30) || (k >= 60 && k < 65);
    end

    // R7 skipped period
    cur_req = "R7"; auto_m = 1; idle(5);
    for (int k = 0; k < 40; k++) begin
      tick();
      if (k == 3) chk("R7 no high side on skip", hs, 0);
      if (k == 3) chk("R7 no low side on skip", ls, 0);
      if (k == 13) chk("R7 pulse after skip", hs, 1);
      cyc = (k == 0 || k == 10); pwm = (k >= 10 && k < 15);
    end

    // R12 disable mid-pulse
    cur_req = "R12"; auto_m = 0; idle(5);
    for (int k = 0; k < 40; k++) begin
      tick();
      if (k == 21) chk("R12 outputs off when disabled", hs, 0);
      if (k == 22) chk("R12 no resume after enable", hs, 0);
      cyc = (k == 0); pwm = (k < 50); en = (k != 20);
    end

    cur_req = "R2";  rand_seg(0, 0, 0, 0, 8000);
    cur_req = "R8";  rand_seg(1, 3, 0, 0, 8000);
    cur_req = "R11"; rand_seg(1, 1, 5, 2, 8000);
    cur_req = "R12"; rand_seg(0, 5, 3, 3, 8000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule